// File: doc/BRIEF.md
# Buffered Router Port Channel

This block is one channel of a router port: an 8-bit word path that an upstream neighbour (another router or a network interface) feeds through a request/acknowledge pair and that a downstream hop drains through another request/acknowledge pair. Inside it, an input-side FIFO and an output-side FIFO, each 64 words deep, are joined by a transfer step. A registered output slot presents each word with its request.

The upstream acknowledge is high by default and drops only while the input buffer is full. An upstream sender that keeps its request up is therefore served one word per clock, with no per-word round trip. On the output side the downstream acknowledge works the same way. While it stays high the channel hands over one word per clock. When it falls, the pending word and its request stay frozen until it rises again. Everything runs on one clock with a synchronous active-high reset.

Top module: `buffered_port_channel`

## Requirements
- R1: While reset is high, and in the first cycle after it, `in_ack` is 1 and `out_req` is 0. Any words held before reset are discarded.
- R2: `in_ack` is 1 whenever the input buffer has room. It falls to 0 only after a word was accepted on the preceding edge that filled that buffer.
- R3: A word is accepted on every rising edge where `in_req` and `in_ack` are both 1, including on consecutive edges without a gap.
- R4: A word offered while `in_ack` is 0 is refused and leaves the stored words unchanged.
- R5: Words leave in the order they were accepted, with their values unchanged.
- R6: A word accepted into an empty channel on edge k drives `out_req` to 1 with that word on `out_data` right after edge k+2.
- R7: While `out_req` is 1 and `out_ack` is 0, `out_req` stays 1 and `out_data` holds its value.
- R8: A word is handed over on each edge where `out_req` and `out_ack` are both 1. With `out_ack` held at 1 and data buffered, words leave on consecutive edges without a gap.
- R9: With `out_ack` held at 0, the channel accepts exactly 2*DEPTH+1 words (129 by default) before `in_ack` falls.
- R10: `out_req` is 0 whenever no accepted word is waiting to be handed over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_req | input | 1 | Upstream has a word on `in_data` |
| in_data | input | WIDTH | Upstream word |
| in_ack | output | 1 | Channel can take a word (high by default) |
| out_req | output | 1 | Word valid on `out_data` |
| out_data | output | WIDTH | Word toward the next hop |
| out_ack | input | 1 | Downstream can take a word; low means busy |

## Verification
A wrong pointer or wrap bit shows at the ports within one buffer depth of traffic. It appears as a missing, repeated or reordered word at the output, or as `in_ack` falling at the wrong word count when the downstream is held busy. A broken hold path shows on the first cycle of downstream busy as a changed `out_data` or a dropped `out_req`. A wrong pipeline depth shows in the three-edge latency of the first word. Refused writes are exposed on the drain that follows, because their distinct values would appear in the output stream.

// File: rtl/noc_chan_pkg.sv
package noc_chan_pkg;

    localparam int CHAN_WIDTH = 8;
    localparam int CHAN_DEPTH = 64;

    // state of the registered output slot
    typedef enum logic {
        SLOT_EMPTY  = 1'b0,
        SLOT_LOADED = 1'b1
    } slot_state_t;

    // full: wrap bits differ while the index parts match
    function automatic logic ptr_full(input logic wrap_w, input logic wrap_r,
                                      input logic idx_equal);
        return (wrap_w != wrap_r) && idx_equal;
    endfunction

    // empty: wrap bits and index parts both match
    function automatic logic ptr_empty(input logic wrap_w, input logic wrap_r,
                                       input logic idx_equal);
        return (wrap_w == wrap_r) && idx_equal;
    endfunction

endpackage

// File: rtl/chan_fifo.sv
module chan_fifo
    import noc_chan_pkg::*;
#(
    parameter int WIDTH = CHAN_WIDTH,
    parameter int DEPTH = CHAN_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW:0]      wr_ptr;
    logic [AW:0]      rd_ptr;
    logic             idx_eq;
    logic             do_push;
    logic             do_pop;

    assign idx_eq    = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign full      = ptr_full(wr_ptr[AW], rd_ptr[AW], idx_eq);
    assign empty     = ptr_empty(wr_ptr[AW], rd_ptr[AW], idx_eq);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign head_data = store[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr[AW-1:0]] <= push_data;
    end

endmodule

// File: rtl/chan_out_stage.sv
module chan_out_stage
    import noc_chan_pkg::*;
#(
    parameter int WIDTH = CHAN_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_empty,
    input  logic [WIDTH-1:0] src_data,
    output logic             src_pop,
    input  logic             dn_ack,
    output logic             dn_req,
    output logic [WIDTH-1:0] dn_data
);
    slot_state_t      slot;
    logic [WIDTH-1:0] slot_data;
    logic             slot_free;

    // the slot frees when empty or when its word is taken this edge
    assign slot_free = (slot == SLOT_EMPTY) || dn_ack;
    assign src_pop   = slot_free && !src_empty;
    assign dn_req    = (slot == SLOT_LOADED);
    assign dn_data   = slot_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot      <= SLOT_EMPTY;
            slot_data <= '0;
        end else if (src_pop) begin
            slot      <= SLOT_LOADED;
            slot_data <= src_data;
        end else if (slot_free) begin
            slot      <= SLOT_EMPTY;
        end
    end

endmodule

// File: rtl/buffered_port_channel.sv
module buffered_port_channel
    import noc_chan_pkg::*;
#(
    parameter int WIDTH = CHAN_WIDTH,
    parameter int DEPTH = CHAN_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_req,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ack,
    output logic             out_req,
    output logic [WIDTH-1:0] out_data,
    input  logic             out_ack
);
    logic             in_full;
    logic             in_empty;
    logic [WIDTH-1:0] in_head;
    logic             out_full;
    logic             out_empty;
    logic [WIDTH-1:0] out_head;
    logic             xfer;
    logic             out_pop;

    assign in_ack = !in_full;
    assign xfer   = !in_empty && !out_full;

    chan_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_in_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (in_req),
        .push_data (in_data),
        .pop       (xfer),
        .head_data (in_head),
        .full      (in_full),
        .empty     (in_empty)
    );

    chan_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_out_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (xfer),
        .push_data (in_head),
        .pop       (out_pop),
        .head_data (out_head),
        .full      (out_full),
        .empty     (out_empty)
    );

    chan_out_stage #(.WIDTH(WIDTH)) u_out_slot (
        .clk       (clk),
        .rst       (rst),
        .src_empty (out_empty),
        .src_data  (out_head),
        .src_pop   (out_pop),
        .dn_ack    (out_ack),
        .dn_req    (out_req),
        .dn_data   (out_data)
    );

endmodule

// File: rtl/buffered_port_channel_chk.sv
module buffered_port_channel_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_req,
    input logic             in_ack,
    input logic             out_req,
    input logic [WIDTH-1:0] out_data,
    input logic             out_ack,
    input logic             out_empty
);
    // R1: state right after reset release
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ack && !out_req));

    // R2: acknowledge falls only after a write attempt on the previous edge
    a_r2_ack_fall_on_write: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ack) |-> $past(in_req));

    // R7: held request keeps its word
    a_r7_hold_when_busy: assert property (@(posedge clk) disable iff (rst)
        (out_req && !out_ack) |=> (out_req && $stable(out_data)));

    // R8: with buffered data and downstream ready, no gap at the output
    a_r8_no_gap: assert property (@(posedge clk) disable iff (rst)
        (out_req && out_ack && !out_empty) |=> out_req);

    // R10: request rises only when the output buffer held a word
    a_r10_req_needs_data: assert property (@(posedge clk) disable iff (rst)
        $rose(out_req) |-> $past(!out_empty));

endmodule

bind buffered_port_channel buffered_port_channel_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_req    (in_req),
    .in_ack    (in_ack),
    .out_req   (out_req),
    .out_data  (out_data),
    .out_ack   (out_ack),
    .out_empty (out_empty)
);

// File: tb/test_buffered_port_channel.sv
`timescale 1ns/1ps
module test_buffered_port_channel;
    localparam int W     = 8;
    localparam int DEPTH = 64;
    localparam int CAP   = 2 * DEPTH + 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_req = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ack;
    logic         out_req;
    logic [W-1:0] out_data;
    logic         out_ack = 1'b1;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int dcount, dfirst, dlast, acc_cnt;
    logic [W-1:0] sb [$];
    bit done = 0;

    always #2.5 clk = ~clk;

    buffered_port_channel i_buffered_port_channel (
        .clk(clk), .rst(rst), .in_req(in_req), .in_data(in_data),
        .in_ack(in_ack), .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: drive, evaluate handshakes before the edge, advance
    task automatic tick(input logic rq, input logic [W-1:0] d, input logic ak);
        in_req  = rq;
        in_data = d;
        out_ack = ak;
        #1;
        if (rq && in_ack) begin
            sb.push_back(d);
            acc_cnt++;
        end
        if (out_req && ak) begin
            if (sb.size() == 0) check(0, "R5 extra word", out_data, -1);
            else begin
                logic [W-1:0] e;
                e = sb.pop_front();
                check(out_data == e, "R5 order/value", out_data, e);
            end
            if (dcount == 0) dfirst = cyc;
            dlast = cyc;
            dcount++;
        end
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_req = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(in_ack == 1'b1, "R1 in_ack in reset", in_ack, 1);
        check(out_req == 1'b0, "R1 out_req in reset", out_req, 0);
        rst = 1'b0;
        sb.delete();
        @(posedge clk);
        #1;
        check(in_ack == 1'b1 && out_req == 1'b0, "R1 after reset", {in_ack, out_req}, 2);
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && (sb.size() != 0 || out_req); i++) tick(0, 0, 1);
        check(sb.size() == 0, "R5 all words delivered", sb.size(), 0);
        check(out_req == 1'b0, "R10 out_req low when empty", out_req, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        int stalls;
        do_reset();

        // R6: three-edge latency into an empty channel
        tick(1, 8'h81, 1);
        check(out_req == 0, "R6 edge1", out_req, 0);
        tick(0, 0, 1);
        check(out_req == 0, "R6 edge2", out_req, 0);
        tick(0, 0, 1);
        check(out_req == 1 && out_data == 8'h81, "R6 edge3", out_data, 8'h81);
        drain();

        // R3/R8: back-to-back stream of 100 words
        dcount = 0;
        stalls = 0;
        for (int i = 0; i < 100; i++) begin
            if (!in_ack) stalls++;
            tick(1, W'(i * 7 + 3), 1);
        end
        check(stalls == 0, "R3 no input stall", stalls, 0);
        drain();
        check(dcount == 100, "R8 delivered count", dcount, 100);
        check(dlast - dfirst == 99, "R8 gapless output", dlast - dfirst, 99);

        // R9/R7/R2/R4: downstream busy, overfill
        acc_cnt = 0;
        for (int i = 0; i < 200; i++) begin
            tick(1, W'(i), 0);
            if (i == 5) held = out_data;
            if (i > 5) check(out_req && out_data == held, "R7 hold while busy", out_data, held);
        end
        check(acc_cnt == CAP, "R9 capacity", acc_cnt, CAP);
        check(in_ack == 0, "R2 in_ack low when full", in_ack, 0);
        tick(1, 8'hEE, 0);
        check(acc_cnt == CAP, "R4 refused write", acc_cnt, CAP);
        drain();
        tick(0, 0, 1);
        check(in_ack == 1, "R2 in_ack back high", in_ack, 1);

        // R5/R7: mixed request and acknowledge patterns
        for (int i = 0; i < 300; i++) tick(i % 5 != 1, W'(i * 13), i % 3 != 0);
        drain();
        for (int i = 0; i < 300; i++) tick(i % 2 == 0, W'(255 - i), i % 7 < 2);
        drain();

        // R1: reset mid-stream discards content
        for (int i = 0; i < 10; i++) tick(1, W'(i), 0);
        do_reset();
        for (int i = 0; i < 5; i++) begin
            tick(0, 0, 1);
            check(out_req == 0, "R1 nothing left after reset", out_req, 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule